// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a programmable countdown timer for an interrupt controller. A 32-bit down-counter advances once per tick, and the ticks come from a free-running prescaler. The prescaler divides the clock by a power of two. The divide code uses an irregular bit layout: bits 1:0 of the divide register form code bits 1:0, and bit 3 of the register becomes code bit 2. The prescale shift is (code + 1) mod 8. Codes 0 to 6 divide the clock by 2 to 128, and code 7 divides by one.

Software programs three registers through one write port: the divide register, a timer entry register and the start value. The timer entry register holds the interrupt vector, a mask bit and a mode bit. Writing the start value loads the counter, clears the prescaler and starts timing from that point. There are two modes:
- One-shot mode counts down to zero once and then holds at zero.
- Periodic mode reloads the start value on the tick after zero, so one period is start value + 1 ticks.

When the counter reaches zero, the block raises a request on a valid/ready output that carries the vector. The mask bit suppresses this request. A read port returns the registers and the live count.

The request output follows valid/ready back-pressure rules:
- Once `irq_valid` is high, it stays high and `irq_vector` does not change until the cycle in which `irq_ready` is also high.
- An expiry that occurs while a request is still waiting is merged into that request and is lost as a separate event.
- An expiry in the same cycle as an accepted request starts a new request.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: The divide register (select 1) stores only the write-data bits kept by mask 0xB. It reads back zero-extended, so writing 0xFF reads back 0xB.
- R2: The divide code is {div[3], div[1:0]}. The counter ticks once every 2^((code+1) mod 8) clock cycles, so register value 0xB gives a tick every cycle and value 0xA gives a tick every 128 cycles.
- R3: A write to the start-value register (select 0) loads that value into the counter and clears the prescaler. After k clock edges, k ticks' worth of time has passed, measured from the write edge.
- R4: In one-shot mode (entry bit 17 = 0) the count after k edges is N − floor(k/2^shift). The count holds at 0 once that reaches 0, and that run produces exactly one expiry.
- R5: In periodic mode (entry bit 17 = 1) the count after t ticks is N − (t mod (N+1)). An expiry occurs each time the count reaches 0.
- R6: On expiry, `irq_valid` rises at the same clock edge at which the count becomes 0, with `irq_vector` equal to entry bits 7:0. If the mask bit (entry bit 16) is set, no request is raised.
- R7: A write to the current-count select (select 3) changes no register and does not disturb the count.
- R8: A start value of 0, whether written while idle or mid-run, stops the timer at a count of 0 and produces no expiry.
- R9: While `irq_valid` is high and `irq_ready` is low, `irq_valid` stays high and `irq_vector` holds. Expiries during that time are merged into the waiting request.
- R10: After reset, every readable register and the count are 0 and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 start value, 1 divide, 2 timer entry, 3 current count (ignored) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Interrupt request accepted when high together with valid |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The bench sweeps the divide codes, including the two ends: code 7, which divides by one, and code 6, which divides by 128. A design that decoded the divide field in plain bit order or skipped the +1 would drift from the expected count trace within one tick.

It runs periodic timers over several periods. An off-by-one in the reload would show up as N-tick periods instead of N+1, or as an expiry count that is wrong.

It stalls the request output while further expiries occur and the vector is reprogrammed. A design that overwrote or dropped the waiting request would show a changed vector or a falling valid.

It also writes a start value of 0, and writes to the current-count select mid-run. A design that fired on a zero start value, or let the ignored write reach the counter, would produce a stray request or a break in the count trace.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int CODE_W = 3;
  localparam int VEC_W = 8;
  localparam int DIV_W = 4;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;
  localparam int ENTRY_MASK_BIT = 16;
  localparam int ENTRY_MODE_BIT = 17;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_CUR   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // Irregular code: register bit 3 supplies code bit 2.
  function automatic logic [CODE_W-1:0] shift_of(input logic [DIV_W-1:0] d);
    logic [CODE_W-1:0] code;
    code = {d[3], d[1:0]};
    return code + 1'b1;
  endfunction
endpackage

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    span = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
    mask = span[PRE_W-1:0];
    tick = (pre_q & mask) == mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  // R2: with a divide above one, two ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && shift != '0) |=> (!tick || shift != $past(shift)));
endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic running_q;

  assign expire = running_q && tick && !load && count == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      running_q <= 1'b0;
    end else if (load) begin
      count     <= load_val;
      running_q <= load_val != '0;
    end else if (running_q && tick) begin
      if (count == '0) begin
        if (periodic) count <= reload_val;
        else          running_q <= 1'b0;
      end else begin
        count <= count - 1'b1;
        if (count == CNT_W'(1) && !periodic) running_q <= 1'b0;
      end
    end
  end

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !load) |=> $stable(count));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && tick && !load && count != '0) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/pct_irq_out.sv
module pct_irq_out import pct_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             masked,
  input  logic [VEC_W-1:0] fire_vec,
  output logic             valid,
  input  logic             ready,
  output logic [VEC_W-1:0] vector
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      vector <= '0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (fire && !masked && (!valid || ready)) begin
        valid  <= 1'b1;
        vector <= fire_vec;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(vector)));
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && masked && !valid) |=> !valid);
endmodule

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer import pct_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector
);
  logic [CNT_W-1:0]  start_q;
  logic [DIV_W-1:0]  div_q;
  entry_t            entry_q;
  logic              load, tick, expire;
  logic [CNT_W-1:0]  count;
  reg_sel_e          wsel, rsel;

  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);
  assign load = wr_en && wsel == SEL_START;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      entry_q <= '0;
    end else if (wr_en) begin
      case (wsel)
        SEL_START: start_q <= wr_data;
        SEL_DIV:   div_q   <= wr_data[DIV_W-1:0] & DIV_KEEP;
        SEL_ENTRY: entry_q <= '{periodic: wr_data[ENTRY_MODE_BIT],
                                masked:   wr_data[ENTRY_MASK_BIT],
                                vector:   wr_data[VEC_W-1:0]};
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_START: rd_data = start_q;
      SEL_DIV:   rd_data[DIV_W-1:0] = div_q;
      SEL_ENTRY: begin
        rd_data[VEC_W-1:0]     = entry_q.vector;
        rd_data[ENTRY_MASK_BIT] = entry_q.masked;
        rd_data[ENTRY_MODE_BIT] = entry_q.periodic;
      end
      default:   rd_data = count;
    endcase
  end

  pct_prescaler #(.SHIFT_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load),
    .shift(shift_of(div_q)), .tick(tick)
  );

  pct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data),
    .reload_val(start_q), .periodic(entry_q.periodic), .tick(tick),
    .count(count), .expire(expire)
  );

  pct_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .fire(expire), .masked(entry_q.masked),
    .fire_vec(entry_q.vector), .valid(irq_valid), .ready(irq_ready),
    .vector(irq_vector)
  );

  p_cur_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_CUR) |=> ($stable(start_q) && $stable(div_q) && $stable(entry_q)));
  p_div_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_q[2] == 1'b0);
endmodule

// File: tb/prescaled_countdown_timer_bench.sv
module prescaled_countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic        irq_ready = 1'b1;
  logic [7:0]  irq_vector;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  prescaled_countdown_timer u_prescaled_countdown_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int shift_for(input logic [3:0] d);
    return ({d[3], d[1:0]} + 1) % 8;
  endfunction

  function automatic longint exp_count(input longint n, input int sh, input bit per, input longint k);
    longint t = k >> sh;
    if (n == 0) return 0;
    if (per) return n - (t % (n + 1));
    return (t >= n) ? 0 : n - t;
  endfunction

  function automatic longint exp_fires(input longint n, input int sh, input bit per, input bit msk, input longint k);
    longint t = k >> sh;
    if (n == 0 || msk) return 0;
    if (per) return (t + 1) / (n + 1);
    return (t >= n) ? 1 : 0;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic setup(input logic [3:0] div, input bit per, input bit msk, input logic [7:0] vec, input logic [31:0] n);
    wr(2'd1, {28'h0, div});
    wr(2'd2, {14'h0, per, msk, 8'h0, vec});
    wr(2'd0, n);
    rd_sel = 2'd3;
  endtask

  // Starts right after the start-value write edge; sample k follows edge k.
  task automatic run_check(input string req, input longint n, input int sh, input bit per,
                           input bit msk, input logic [7:0] vec, input int kmax, input int poke_at);
    int fired = 0;
    for (int k = 1; k <= kmax; k++) begin
      @(posedge clk);
      #1 wr_en = 1'b0;
      @(negedge clk);
      check(req, rd_data, exp_count(n, sh, per, k));
      if (irq_valid) begin
        fired++;
        check("R6 vector", irq_vector, vec);
      end
      if (k == poke_at) begin
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'hFFFF_FFFF;
      end
    end
    check({req, " expiries"}, fired, exp_fires(n, sh, per, msk, kmax));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rd_sel = s[1:0];
      #1 check("R10 reset reg", rd_data, 0);
    end
    check("R10 reset valid", irq_valid, 0);

    // R1 divide masking
    wr(2'd1, 32'hFF);
    rd_sel = 2'd1;
    @(negedge clk);
    check("R1 div readback", rd_data, 32'hB);
    wr(2'd1, 32'h4);
    @(negedge clk);
    check("R1 div bit2 dropped", rd_data, 0);

    // R2 divide extremes: code 7 (divide 1) and code 6 (divide 128)
    setup(4'hB, 1'b0, 1'b0, 8'h21, 32'd5);
    run_check("R2 R4 div1 oneshot", 5, 0, 0, 0, 8'h21, 12, 0);
    setup(4'hA, 1'b0, 1'b0, 8'h22, 32'd2);
    run_check("R2 div128", 2, 7, 0, 0, 8'h22, 300, 0);

    // R5 periodic with divide 2
    setup(4'h0, 1'b1, 1'b0, 8'h33, 32'd3);
    run_check("R5 periodic", 3, 1, 1, 0, 8'h33, 40, 0);

    // R7 write to current count is ignored mid-run
    setup(4'hB, 1'b0, 1'b0, 8'h44, 32'd20);
    run_check("R7 cur write ignored", 20, 0, 0, 0, 8'h44, 30, 4);

    // R6 masked expiry
    setup(4'hB, 1'b1, 1'b1, 8'h55, 32'd2);
    run_check("R6 masked", 2, 0, 1, 1, 8'h55, 20, 0);

    // R8 zero start value stops the timer mid-run
    setup(4'hB, 1'b1, 1'b0, 8'h66, 32'd50);
    run_check("R3 run", 50, 0, 1, 0, 8'h66, 10, 0);
    wr(2'd0, 32'd0);
    run_check("R8 zero start", 0, 0, 1, 0, 8'h66, 100, 0);

    // R3 restart: reload mid-run restarts timing from the write
    setup(4'h1, 1'b0, 1'b0, 8'h67, 32'd9);
    run_check("R3 first", 9, 2, 0, 0, 8'h67, 7, 0);
    wr(2'd0, 32'd4);
    run_check("R3 restart", 4, 2, 0, 0, 8'h67, 30, 0);

    // R9 back-pressure and merging
    irq_ready = 1'b0;
    setup(4'hB, 1'b0, 1'b0, 8'h5A, 32'd3);
    repeat (3) @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R9 held valid", irq_valid, 1);
      check("R9 held vector", irq_vector, 8'h5A);
    end
    wr(2'd2, {14'h0, 1'b1, 1'b0, 8'h0, 8'h77});
    wr(2'd0, 32'd2);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R9 merged valid", irq_valid, 1);
    check("R9 merged vector", irq_vector, 8'h5A);
    wr(2'd0, 32'd0);
    @(negedge clk);
    irq_ready = 1'b1;
    @(negedge clk);
    check("R9 accepted", irq_valid, 0);

    // Random trials
    for (int tr = 0; tr < 16; tr++) begin
      logic [3:0] dv = 4'($urandom_range(0, 15));
      bit pe = 1'($urandom_range(0, 1));
      bit mk = ($urandom_range(0, 3) == 0);
      logic [7:0] vc = 8'($urandom_range(0, 255));
      int nn = pe ? $urandom_range(1, 6) : $urandom_range(1, 12);
      int sh = shift_for(dv);
      int km = pe ? 3 * (nn + 1) * (1 << sh) : nn * (1 << sh) + 1 + $urandom_range(0, 60);
      setup(dv, pe, mk, vc, 32'(nn));
      run_check(pe ? "R5 R2 random" : "R4 R2 random", nn, sh, pe, mk, vc, km, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule